// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the programmed settings of a clock synthesizer: a 9-bit feedback divide value M and a 1-bit post-divider select N. Software or board straps can set them in two ways. A parallel M bus is gated by an active-low load strobe: the bus flows through while the strobe is low and is captured when the strobe rises. A three-wire serial port (data, clock, load) fills a 10-bit shift register. Its contents are transferred when the load pin rises, frozen when it falls, and passed straight through on every serial clock while the load pin stays high.

All pins are asynchronous to the single system clock. Each pin passes through a two-flop synchronizer and is edge-detected, so a pin change reaches the outputs on the third system clock edge after it is sampled. The block drives the active M and N values and a flag that says whether M lies in the range where the loop can lock. A master reset pin is passed on as a divider reset and leaves the stored settings alone.

Top module: `synth_div_cfg`

## Requirements
- R1: After system reset, M is 256, N is 0, the lock flag is 1 and the divider reset is 0.
- R2: While the parallel strobe is low, the active M follows the M bus.
- R3: A rising parallel strobe captures the bus value. While the strobe stays high and no serial transfer occurs, later bus changes do not alter M.
- R4: Any parallel update (transparent or captured) sets N to 0, which selects divide-by-2. N = 1 selects divide-by-4.
- R5: With the strobe high, each rising serial clock shifts serial data into a 10-bit register. The frame is sent N first, then M bit 8 down to M bit 0, so M bit 0 is the last bit.
- R6: With the strobe high, a rising serial load pin copies the shift register into N (bit 9) and M (bits 8..0).
- R7: After the serial load pin falls, further serial clocks fill the shift register but leave M and N unchanged.
- R8: While the serial load pin is high with the strobe high, every rising serial clock updates M and N to the new shift register contents.
- R9: While the parallel strobe is low, serial clock and serial load activity neither changes M and N nor alters the shift register.
- R10: When a parallel strobe rise and a serial load rise are seen in the same cycle, the serial transfer wins.
- R11: The lock flag is 1 exactly when 125 <= M <= 350.
- R12: The divider reset output follows the master reset pin, and asserting it leaves M and N unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| m_bus | input | 9 | Parallel feedback divide value |
| par_load_n | input | 1 | Parallel strobe, low = transparent, rise = capture |
| ser_clk | input | 1 | Serial shift clock pin |
| ser_data | input | 1 | Serial data pin |
| ser_load | input | 1 | Serial transfer/hold pin |
| mreset_in | input | 1 | Master reset pin for the dividers |
| m_active | output | 9 | Active feedback divide value |
| n_sel | output | 1 | Post-divider select, 0 = /2, 1 = /4 |
| lock_ok | output | 1 | M lies in the lockable range |
| div_reset | output | 1 | Synchronized divider reset |

## Verification
A wrong shift register shows up only at the next serial transfer or pass-through clock. The bench therefore reads the register through the outputs after every frame, and after every clock in pass-through mode. A wrong update priority or a bad hold condition shows up three system clocks after the offending pin edge, as an M or N value that differs from the bench's model. Pin activity that should be ignored is checked by later moving the register to the outputs and comparing it with the value expected before that activity.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W   = 9;
  localparam int SR_W  = M_W + 1;
  localparam int M_MIN = 125;
  localparam int M_MAX = 350;
  localparam int M_DEF = 256;

  function automatic logic m_lockable(input logic [M_W-1:0] m);
    return (int'(m) >= M_MIN) && (int'(m) <= M_MAX);
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cfg_edge.sv
module cfg_edge #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_rise
    assign rise[i] = lvl[i] & ~prev[i];
  end
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  assign q_next = en ? {q[W-2:0], din} : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/synth_div_cfg.sv
module synth_div_cfg
  import synth_cfg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_bus,
  input  logic           par_load_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           mreset_in,
  output logic [M_W-1:0] m_active,
  output logic           n_sel,
  output logic           lock_ok,
  output logic           div_reset
);
  localparam int CTL_W = 5;
  localparam int I_PAR = 4;
  localparam int I_SL  = 3;
  localparam int I_SC  = 2;
  localparam int I_SD  = 1;
  localparam int I_MR  = 0;
  localparam logic [CTL_W-1:0] CTL_RST = CTL_W'(1) << I_PAR;

  logic [CTL_W-1:0] ctl_raw, ctl_s, ctl_rise;
  logic [M_W-1:0]   m_s;
  logic [SR_W-1:0]  sr_q, sr_next;

  assign ctl_raw = {par_load_n, ser_load, ser_clk, ser_data, mreset_in};

  cfg_sync #(.W(CTL_W), .RST_VAL(CTL_RST)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s));

  cfg_sync #(.W(M_W), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(m_bus), .q(m_s));

  cfg_edge #(.W(CTL_W), .RST_VAL(CTL_RST)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ctl_s), .rise(ctl_rise));

  // named internal events
  logic par_hi, par_rise, sl_hi, sl_rise, sc_rise;
  logic shift_en, serial_evt, par_evt;

  assign par_hi     = ctl_s[I_PAR];
  assign par_rise   = ctl_rise[I_PAR];
  assign sl_hi      = ctl_s[I_SL];
  assign sl_rise    = ctl_rise[I_SL];
  assign sc_rise    = ctl_rise[I_SC];
  assign shift_en   = par_hi & sc_rise;
  assign serial_evt = par_hi & sl_hi & (sl_rise | sc_rise);
  assign par_evt    = ~par_hi | par_rise;

  cfg_shift #(.W(SR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(shift_en), .din(ctl_s[I_SD]),
    .q(sr_q), .q_next(sr_next));

  logic [M_W-1:0] m_q;
  logic           n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= M_W'(M_DEF);
      n_q <= 1'b0;
    end else if (serial_evt) begin
      m_q <= sr_next[M_W-1:0];
      n_q <= sr_next[SR_W-1];
    end else if (par_evt) begin
      m_q <= m_s;
      n_q <= 1'b0;
    end
  end

  assign m_active  = m_q;
  assign n_sel     = n_q;
  assign lock_ok   = m_lockable(m_q);
  assign div_reset = ctl_s[I_MR];

  // R2
  par_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!par_hi) |-> (m_q == $past(m_s)));

  // R4
  par_n_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(par_evt && !serial_evt) |-> (n_q == 1'b0));

  // R6
  ser_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(serial_evt) |-> ({n_q, m_q} == $past(sr_next)));

  // R7
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(par_hi && !sl_hi && !par_rise) |-> ($stable(m_q) && $stable(n_q)));

  // R9
  shift_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q != $past(sr_q)) |-> $past(par_hi));

  // R10
  ser_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(par_rise && sl_rise) |-> (m_q == $past(sr_next[M_W-1:0])));
endmodule

// File: tb/tb_synth_div_cfg.sv
module tb_synth_div_cfg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] m_bus = 9'd0;
  logic       par_load_n = 1'b1;
  logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, mreset_in = 1'b0;
  logic [8:0] m_active;
  logic       n_sel, lock_ok, div_reset;

  int checks = 0;
  int errors = 0;
  logic [9:0] sr_m = '0;
  int exp_m = 256;
  int exp_n = 0;

  always #4 clk = ~clk;

  synth_div_cfg dut (
    .clk(clk), .rst_n(rst_n), .m_bus(m_bus), .par_load_n(par_load_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .mreset_in(mreset_in), .m_active(m_active), .n_sel(n_sel),
    .lock_ok(lock_ok), .div_reset(div_reset));

  function automatic int lock_exp(input int m);
    return (m > 124 && m < 351) ? 1 : 0;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " M"}, int'(m_active), exp_m);
    chk({req, " N"}, int'(n_sel), exp_n);
    chk({req, " R11 lock"}, int'(lock_ok), lock_exp(exp_m));
  endtask

  // one serial bit; shift happens only with strobe high (R5, R9)
  task automatic ser_bit(input logic b);
    ser_data = b; tick(4);
    ser_clk = 1'b1; tick(4);
    if (par_load_n) begin
      sr_m = {sr_m[8:0], b};
      if (ser_load) begin exp_n = int'(sr_m[9]); exp_m = int'(sr_m[8:0]); end
    end
    ser_clk = 1'b0; tick(4);
  endtask

  task automatic ser_frame(input logic [9:0] f);
    for (int i = 9; i >= 0; i--) ser_bit(f[i]);
  endtask

  task automatic ser_xfer();
    ser_load = 1'b1; tick(4);
    exp_n = int'(sr_m[9]); exp_m = int'(sr_m[8:0]);
    chk_state("R6 transfer");
    ser_load = 1'b0; tick(4);
  endtask

  task automatic par_load(input logic [8:0] m);
    par_load_n = 1'b0; m_bus = m; tick(4);
    exp_m = int'(m); exp_n = 0;
    chk_state("R2 R4 transparent");
    par_load_n = 1'b1; tick(4);
    chk_state("R3 capture");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    logic [8:0] bnd [4];
    seed = $urandom(32'd2024);
    bnd[0] = 9'd124; bnd[1] = 9'd125; bnd[2] = 9'd350; bnd[3] = 9'd351;

    tick(3); rst_n = 1'b1; tick(1);
    // R1 reset state
    chk_state("R1 reset");
    chk("R1 div_reset", int'(div_reset), 0);

    // R2 transparent flow of several values
    par_load_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      m_bus = 9'($urandom); tick(4);
      exp_m = int'(m_bus); exp_n = 0;
      chk_state("R2 flow");
    end
    par_load_n = 1'b1; tick(4);
    // R3 bus ignored while strobe high
    m_bus = ~m_bus; tick(5);
    chk_state("R3 hold");

    // R11 boundaries via parallel path
    foreach (bnd[k]) par_load(bnd[k]);
    par_load(9'd0); par_load(9'd511); par_load(9'h100);

    // R5 R6 serial frames, random and boundaries, N=1 included
    for (int i = 0; i < 8; i++) begin
      ser_frame(10'($urandom)); ser_xfer();
    end
    ser_frame({1'b1, 9'd350}); ser_xfer();
    chk("R5 N first /4", int'(n_sel), 1);
    ser_frame({1'b0, 9'd124}); ser_xfer();
    chk("R5 M0 last", int'(m_active), 124);

    // R7 freeze: more clocks after fall leave outputs alone
    ser_frame({1'b1, 9'd300}); ser_xfer();
    ser_frame({1'b0, 9'd200}); tick(2);
    chk_state("R7 frozen");
    chk("R7 M still 300", int'(m_active), 300);
    ser_xfer();
    chk("R7 later transfer", int'(m_active), 200);

    // R4 parallel after serial clears N
    ser_frame({1'b1, 9'd222}); ser_xfer();
    par_load(9'd333);
    chk("R4 N cleared", int'(n_sel), 0);

    // R8 pass-through while load high
    ser_load = 1'b1; tick(4);
    exp_n = int'(sr_m[9]); exp_m = int'(sr_m[8:0]);
    for (int i = 0; i < 12; i++) begin
      ser_bit(1'($urandom));
      chk_state("R8 pass-through");
    end
    ser_load = 1'b0; tick(4);

    // R9 serial ignored while strobe low
    ser_frame({1'b1, 9'd150});
    par_load_n = 1'b0; m_bus = 9'd140; tick(4);
    exp_m = 140; exp_n = 0;
    ser_frame({1'b0, 9'd400});
    ser_load = 1'b1; tick(4); ser_load = 1'b0; tick(4);
    chk_state("R9 ignored");
    par_load_n = 1'b1; tick(4);
    ser_xfer();
    chk("R9 shift reg untouched", int'(m_active), 150);
    chk("R9 shift reg N", int'(n_sel), 1);

    // R10 simultaneous strobe rise and load rise
    ser_frame({1'b1, 9'd177});
    par_load_n = 1'b0; m_bus = 9'd99; tick(4);
    par_load_n = 1'b1; ser_load = 1'b1; tick(4);
    exp_m = 177; exp_n = 1;
    chk_state("R10 serial wins");
    ser_load = 1'b0; tick(4);

    // R12 master reset pass-through
    mreset_in = 1'b1; tick(4);
    chk("R12 div_reset high", int'(div_reset), 1);
    chk_state("R12 settings kept");
    mreset_in = 1'b0; tick(4);
    chk("R12 div_reset low", int'(div_reset), 0);
    chk_state("R12 after release");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule